// File: doc/BRIEF.md
# Expansion Bus Slave Glue

This block is the glue logic for an 8-bit peripheral card on a 68000-style asynchronous expansion bus. It watches the address strobe, the upper data strobe, the read/write line and the three highest address bits. When the card is addressed it pulls a board-select line low at once and raises a ready line one sample clock later. It also drives active-low read and write strobes toward the peripheral and controls the enable and direction of the card's data buffer.

A free-running system clock samples every bus input through a two-flop synchronizer. The address strobe and the top address bits also feed a combinational path to board-select, so that the ready deadline can be met. A bus-phase input marks the start of the data-output-enable phase. On reads the buffer is not turned on toward the bus until that phase has been seen, which keeps the card off the bus while the backplane buffers and other slaves may still be driving it. Once enabled, the buffer stays on until the strobes are negated. A cycle moves through three states: idle, selected and waiting for the data phase, and driving.

Top module: `xbus_slave_glue`

## Requirements
- R1: After a synchronous reset with the strobes high, per_rd_n, per_wr_n and buf_en_n are 1, and buf_dir_to_bus and ready are 0.
- R2: slave_n is 0 exactly when bus_as_n is 0 and bus_addr_hi equals BASE_SEL (default 3'b111). There is no clock delay on this path.
- R3: ready goes to 1 at the first rising clock edge at which the card is selected (bus_as_n low, address matching). It does not depend on bus_uds_n.
- R4: On a selected read (bus_rnw=1), buf_en_n stays 1 until bus_doe has been seen at 1. It goes to 0 at the third clock edge after bus_doe rises.
- R5: On a selected read with bus_uds_n low, per_rd_n goes to 0 at the third clock edge after the strobes fall, and not earlier.
- R6: Once read data is driven, buf_en_n stays 0 while the strobes remain low, even if bus_doe falls again.
- R7: On a selected write (bus_rnw=0), per_wr_n and buf_en_n go to 0 at the third clock edge after the strobes fall, whatever the level of bus_doe. per_rd_n stays 1.
- R8: When bus_addr_hi does not match, no strobe, buffer enable, board-select or ready is produced.
- R9: At the first clock edge after bus_as_n rises, per_rd_n, per_wr_n and buf_en_n return to 1 and ready returns to 0. This holds even if bus_uds_n is still low.
- R10: With bus_as_n low and the address matching but bus_uds_n high, board-select and ready assert but neither peripheral strobe does.
- R11: buf_dir_to_bus is 1 only during a selected read cycle. In every other case it is 0, so the buffer points toward the peripheral.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sample clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_as_n | input | 1 | Address strobe, active low |
| bus_uds_n | input | 1 | Upper data strobe, active low |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| bus_addr_hi | input | 3 | Highest address bits |
| bus_doe | input | 1 | Data-output-enable bus phase, active high |
| slave_n | output | 1 | Board select to the bus, active low, combinational |
| ready | output | 1 | Ready to the bus, registered |
| per_rd_n | output | 1 | Peripheral read strobe, active low |
| per_wr_n | output | 1 | Peripheral write strobe, active low |
| buf_en_n | output | 1 | Data buffer enable, active low |
| buf_dir_to_bus | output | 1 | Buffer direction, 1 = toward bus |

## Verification
The bench sweeps every address against both directions and counts edges so that strobes arriving a cycle early or late are caught. A design that keyed buffer enable to the strobes alone would drive the bus before the data phase; the late-phase read exposes this. The bench also drops the phase input mid-drive, which catches a design that releases read data early. Two further cases are an address strobe raised while the data strobe stays low, which must end the cycle within one edge rather than two or three, and a missing data strobe, which must not fire a peripheral strobe.

// File: rtl/xbs_pkg.sv
package xbs_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_WAIT_DOE = 2'd1,
        ST_DRIVE    = 2'd2
    } cyc_state_t;

    // Bus inputs converted to active-high flags; 'as' is the top bit.
    typedef struct packed {
        logic              as;
        logic              uds;
        logic              rnw;
        logic              doe;
        logic [ADDR_W-1:0] addr;
    } bus_sample_t;

    localparam int SAMPLE_W = $bits(bus_sample_t);
    localparam int AS_BIT   = SAMPLE_W - 1;

    function automatic logic addr_hit(input logic [ADDR_W-1:0] a,
                                      input logic [ADDR_W-1:0] base);
        return (a == base);
    endfunction

endpackage

// File: rtl/xbs_sync.sv
module xbs_sync #(
    parameter int W       = 8,
    parameter int STAGES  = 2,
    parameter int TAP_BIT = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] rst_val,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic         tap_first
);
    logic [W-1:0] stage [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)
                stage[i] <= rst_val;
            else if (i == 0)
                stage[i] <= d;
            else
                stage[i] <= stage[(i == 0) ? 0 : i - 1];
        end
    end

    assign q         = stage[STAGES-1];
    assign tap_first = stage[0][TAP_BIT];
endmodule

// File: rtl/xbs_decode.sv
module xbs_decode
    import xbs_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BASE_SEL = '1
) (
    input  logic              raw_as,
    input  logic [ADDR_W-1:0] raw_addr,
    input  bus_sample_t       synced,
    output logic              fast_sel,
    output logic              cyc_sel
);
    // Fast path: unsynchronized strobe and address, meets the ready deadline.
    assign fast_sel = raw_as && addr_hit(raw_addr, BASE_SEL);
    // Slow path: synchronized inputs, data strobe required.
    assign cyc_sel  = synced.as && synced.uds && addr_hit(synced.addr, BASE_SEL);
endmodule

// File: rtl/xbs_cycle_fsm.sv
module xbs_cycle_fsm
    import xbs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sel,
    input  logic rnw,
    input  logic doe,
    input  logic gate,
    output logic rd_act,
    output logic wr_act,
    output logic drv_act,
    output logic dir_bus
);
    cyc_state_t state_q, state_d;
    logic       is_read_q, is_read_d;

    always_comb begin
        state_d   = state_q;
        is_read_d = is_read_q;
        unique case (state_q)
            ST_IDLE: begin
                if (sel) begin
                    is_read_d = rnw;
                    state_d   = (rnw && !doe) ? ST_WAIT_DOE : ST_DRIVE;
                end
            end
            ST_WAIT_DOE: begin
                if (!sel)     state_d = ST_IDLE;
                else if (doe) state_d = ST_DRIVE;
            end
            ST_DRIVE: begin
                if (!sel) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            is_read_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            is_read_q <= is_read_d;
        end
    end

    logic busy;
    assign busy    = gate && (state_q != ST_IDLE);
    assign rd_act  = busy && is_read_q;
    assign dir_bus = busy && is_read_q;
    assign wr_act  = gate && !is_read_q && (state_q == ST_DRIVE);
    assign drv_act = gate && (state_q == ST_DRIVE);
endmodule

// File: rtl/xbus_slave_glue.sv
module xbus_slave_glue
    import xbs_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BASE_SEL    = 3'b111,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_as_n,
    input  logic              bus_uds_n,
    input  logic              bus_rnw,
    input  logic [ADDR_W-1:0] bus_addr_hi,
    input  logic              bus_doe,
    output logic              slave_n,
    output logic              ready,
    output logic              per_rd_n,
    output logic              per_wr_n,
    output logic              buf_en_n,
    output logic              buf_dir_to_bus
);
    bus_sample_t raw, synced, idle_val;
    logic        as_first, fast_sel, cyc_sel;
    logic        rd_act, wr_act, drv_act, dir_bus;
    logic        ready_q;

    assign raw      = '{as: !bus_as_n, uds: !bus_uds_n, rnw: bus_rnw,
                        doe: bus_doe, addr: bus_addr_hi};
    assign idle_val = '0;

    xbs_sync #(.W(SAMPLE_W), .STAGES(SYNC_STAGES), .TAP_BIT(AS_BIT)) u_sync (
        .clk(clk), .rst(rst), .rst_val(idle_val), .d(raw),
        .q(synced), .tap_first(as_first)
    );

    xbs_decode #(.BASE_SEL(BASE_SEL)) u_dec (
        .raw_as(raw.as), .raw_addr(raw.addr), .synced(synced),
        .fast_sel(fast_sel), .cyc_sel(cyc_sel)
    );

    xbs_cycle_fsm u_fsm (
        .clk(clk), .rst(rst), .sel(cyc_sel), .rnw(synced.rnw),
        .doe(synced.doe), .gate(as_first),
        .rd_act(rd_act), .wr_act(wr_act), .drv_act(drv_act), .dir_bus(dir_bus)
    );

    always_ff @(posedge clk) begin
        if (rst) ready_q <= 1'b0;
        else     ready_q <= fast_sel;
    end

    assign slave_n        = !fast_sel;
    assign ready          = ready_q;
    assign per_rd_n       = !rd_act;
    assign per_wr_n       = !wr_act;
    assign buf_en_n       = !drv_act;
    assign buf_dir_to_bus = dir_bus;
endmodule

// File: rtl/xbus_slave_glue_chk.sv
module xbus_slave_glue_chk (
    input logic clk,
    input logic rst,
    input logic bus_as_n,
    input logic bus_doe,
    input logic ready,
    input logic per_rd_n,
    input logic per_wr_n,
    input logic buf_en_n,
    input logic buf_dir_to_bus
);
    p_strobes_exclusive_r7: assert property (@(posedge clk) disable iff (rst)
        !(!per_rd_n && !per_wr_n));

    p_doe_gate_r4: assert property (@(posedge clk) disable iff (rst)
        ($fell(buf_en_n) && buf_dir_to_bus) |-> $past(bus_doe, 3));

    p_abort_release_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_as_n) |=> (per_rd_n && per_wr_n && buf_en_n && !ready));

    p_write_inward_r11: assert property (@(posedge clk) disable iff (rst)
        !per_wr_n |-> !buf_dir_to_bus);

    p_buf_with_strobe_r6: assert property (@(posedge clk) disable iff (rst)
        !buf_en_n |-> (!per_rd_n || !per_wr_n));
endmodule

bind xbus_slave_glue xbus_slave_glue_chk u_chk (
    .clk(clk), .rst(rst), .bus_as_n(bus_as_n), .bus_doe(bus_doe),
    .ready(ready), .per_rd_n(per_rd_n), .per_wr_n(per_wr_n),
    .buf_en_n(buf_en_n), .buf_dir_to_bus(buf_dir_to_bus)
);

// File: tb/sim_xbus_slave_glue.sv
module sim_xbus_slave_glue;
    logic       clk = 1'b0;
    logic       rst;
    logic       as_n, uds_n, rnw, doe;
    logic [2:0] addr;
    logic       slave_n, ready, rd_n, wr_n, en_n, dir;
    int         checks = 0;
    int         errors = 0;
    bit         done   = 1'b0;

    always #2 clk = ~clk;

    xbus_slave_glue u0 (
        .clk(clk), .rst(rst), .bus_as_n(as_n), .bus_uds_n(uds_n),
        .bus_rnw(rnw), .bus_addr_hi(addr), .bus_doe(doe),
        .slave_n(slave_n), .ready(ready), .per_rd_n(rd_n), .per_wr_n(wr_n),
        .buf_en_n(en_n), .buf_dir_to_bus(dir)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic release_bus();
        as_n = 1'b1; uds_n = 1'b1; doe = 1'b0;
        tick(4);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; as_n = 1'b1; uds_n = 1'b1; rnw = 1'b1; doe = 1'b0; addr = 3'd0;
        tick(3);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 rd_n", rd_n, 1'b1);
        chk("R1 wr_n", wr_n, 1'b1);
        chk("R1 buf_en_n", en_n, 1'b1);
        chk("R1 dir", dir, 1'b0);
        chk("R1 ready", ready, 1'b0);

        // Sweep: all addresses x both directions, data phase already present
        for (int a = 0; a < 8; a++) begin
            for (int w = 0; w < 2; w++) begin
                logic hit, rd;
                hit  = (a == 7);
                rd   = (w == 0);
                addr = a[2:0]; rnw = rd; doe = 1'b1;
                as_n = 1'b0; uds_n = 1'b0;
                #1;
                chk("R2 slave_n", slave_n, !hit);
                tick(1);
                chk("R3 ready", ready, hit);
                tick(1);
                chk("R5 no early rd", rd_n, 1'b1);
                chk("R7 no early wr", wr_n, 1'b1);
                tick(1);
                chk("R5/R8 rd_n", rd_n, !(hit && rd));
                chk("R7/R8 wr_n", wr_n, !(hit && !rd));
                chk("R7/R8 buf_en_n", en_n, !hit);
                chk("R11 dir", dir, hit && rd);
                as_n = 1'b1; uds_n = 1'b1; doe = 1'b0;
                tick(1);
                chk("R9 rd_n", rd_n, 1'b1);
                chk("R9 wr_n", wr_n, 1'b1);
                chk("R9 buf_en_n", en_n, 1'b1);
                chk("R9 ready", ready, 1'b0);
                tick(3);
            end
        end

        // Read with late data phase, then phase drops while strobes held
        addr = 3'd7; rnw = 1'b1; doe = 1'b0; as_n = 1'b0; uds_n = 1'b0;
        tick(5);
        chk("R5 rd_n wait", rd_n, 1'b0);
        chk("R4 held off", en_n, 1'b1);
        chk("R11 dir read", dir, 1'b1);
        doe = 1'b1;
        tick(2);
        chk("R4 still off", en_n, 1'b1);
        tick(1);
        chk("R4 enabled", en_n, 1'b0);
        doe = 1'b0;
        tick(4);
        chk("R6 held", en_n, 1'b0);
        chk("R6 rd held", rd_n, 1'b0);
        as_n = 1'b1; uds_n = 1'b1;
        tick(1);
        chk("R9 read end", en_n, 1'b1);
        tick(3);

        // Data strobe missing
        addr = 3'd7; rnw = 1'b0; as_n = 1'b0; uds_n = 1'b1;
        tick(4);
        chk("R10 slave_n", slave_n, 1'b0);
        chk("R10 ready", ready, 1'b1);
        chk("R10 wr_n", wr_n, 1'b1);
        chk("R10 buf_en_n", en_n, 1'b1);
        release_bus();

        // Write without data phase, then abort with data strobe still low
        addr = 3'd7; rnw = 1'b0; doe = 1'b0; as_n = 1'b0; uds_n = 1'b0;
        tick(3);
        chk("R7 wr_n", wr_n, 1'b0);
        chk("R7 buf_en_n", en_n, 1'b0);
        chk("R7 rd_n", rd_n, 1'b1);
        chk("R11 dir write", dir, 1'b0);
        as_n = 1'b1;
        tick(1);
        chk("R9 abort wr_n", wr_n, 1'b1);
        chk("R9 abort buf", en_n, 1'b1);
        chk("R9 abort ready", ready, 1'b0);
        chk("R2 deselect", slave_n, 1'b1);
        release_bus();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule